// File: doc/BRIEF.md
# Double-Transition Training and Validity Transmitter

This block drives the sending side of a double-transition data phase on a parallel bus of DW data lines plus a CRC-available line and a free-running validity line. Each clock cycle is one transfer slot, and the request strobe changes on every slot. A request edge therefore carries one data word, so a full strobe period carries two words. When a phase begins, the block sends a fixed three-section training preamble so that the far receiver can tune its equalizer and deskew. It then streams data that comes from a ready/valid source in two-word pairs.

Data validity is not sent on a strobe of its own. The validity line toggles on every rising slot of the request strobe. When the block leaves it unchanged at one of those slots, validity has changed. The first such hold after training marks the start of valid data. When the source has no pair ready, the block sends filler words and keeps the line in the invalid phase. The CRC-available line goes high on every word of the final stream unit. For each line, the block also produces a strong-drive enable for precompensating output drivers.

A retain-training input lets a phase skip the preamble and start with data. A done pulse marks the return to idle after the last pair.

Top module: `dtx_link_tx`

## Requirements
- R1: After reset, every bus line (`db_out`, `crca_out`, `p1_out`, `req_out`) is low, and `drv_boost`, `done` and `src_ready` are low.
- R2: A `phase_start` sampled in idle with `keep_train` low makes the first training slot appear at the next edge. The first section holds all lines and `req_out` low for A_HOLD_SLOTS (32) slots.
- R3: The second section lasts A_TOG_SLOTS (128) slots. In it, `req_out` and every data, CRC-available and validity line are 1 on the first slot and invert on every later slot.
- R4: The third section lasts B_SLOTS (48) slots. `req_out` alternates 1,0. All data lines, `crca_out` and `p1_out` repeat 1,1,0,0.
- R5: The fourth section lasts 16*C_REPS (128) slots. All data lines and `crca_out` send the serial pattern 0000010011111011, leftmost bit first, once every 16 slots. `req_out` alternates 1,0. `p1_out` is 1 on the first two slots and inverts at each later slot where `req_out` rises.
- R6: A `phase_start` with `keep_train` high skips training. Data slots begin at the next edge.
- R7: `src_ready` is high only in the cycle before a slot where `req_out` rises. Each handshake is one pair. The low half `src_data[DW-1:0]` goes out in the `req_out`=1 slot and the high half in the following `req_out`=0 slot.
- R8: The data phase begins with validity invalid and `p1_out` at 0. At each rising slot, `p1_out` inverts when the pair's validity equals that of the previous pair and holds when it differs. It holds on falling slots.
- R9: When no pair is handed over, both slots carry FILL_WORD (default 16'h5A5A) with `crca_out` low.
- R10: `crca_out` is high on both slots of a valid pair handed over with `src_last_unit` high.
- R11: In the slot after the high half of a pair handed over with `src_end`, all lines are low and `done` is high. In the slot after that, `done` is low.
- R12: `drv_boost` has bit order {req, p1, crca, db[DW-1:0]}. With `pcomp_en` high, a bit is high exactly when that line differs from its value in the previous slot. With `pcomp_en` low, all bits are 0.
- R13: A `phase_start` raised while a phase is in progress does not change the output sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_start | input | 1 | Begin a data-in phase (sampled in idle) |
| keep_train | input | 1 | Skip the training preamble for this phase |
| pcomp_en | input | 1 | Enable per-line strong-drive flags |
| src_valid | input | 1 | Source offers a pair |
| src_ready | output | 1 | Block takes a pair this cycle |
| src_data | input | 2*DW | Pair: low half first, high half second |
| src_last_unit | input | 1 | Pair belongs to the final stream unit |
| src_end | input | 1 | Pair is the last of the phase |
| db_out | output | DW | Data lines |
| crca_out | output | 1 | CRC-available line |
| p1_out | output | 1 | Validity-phase line |
| req_out | output | 1 | Request strobe |
| drv_boost | output | DW+3 | Strong-drive enables {req, p1, crca, db} |
| done | output | 1 | One-slot pulse on return to idle |

## Verification
Every output is registered, so the slot chosen by inputs sampled at an edge appears right after that edge. Training slot s shows s+1 edges after the `phase_start` edge. The low half of a pair shows at the handshake edge and its high half one edge later. `done` rises one edge after the high half of the end pair. `src_ready` is combinational and is checked in the same cycle as the inputs. The bench drives inputs 2 ns after a rising edge and tags each expected slot with the cycle number at which it is due. The monitor compares at the falling edge only when that cycle number comes up, so no check lands a slot early or late.

// File: rtl/dtx_pkg.sv
package dtx_pkg;
  typedef enum logic [2:0] {
    SEC_IDLE   = 3'd0,
    SEC_A_HOLD = 3'd1,
    SEC_A_TOG  = 3'd2,
    SEC_B      = 3'd3,
    SEC_C      = 3'd4,
    SEC_DATA   = 3'd5
  } sect_e;

  // Serial word for the last training section, first-sent bit at the MSB.
  localparam logic [15:0] C_SERIAL = 16'b0000_0100_1111_1011;
endpackage

// File: rtl/dtx_seq_ctl.sv
module dtx_seq_ctl
  import dtx_pkg::*;
#(
  parameter int A_HOLD_SLOTS = 32,
  parameter int A_TOG_SLOTS  = 128,
  parameter int B_SLOTS      = 48,
  parameter int C_SLOTS      = 128,
  parameter int IW           = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          phase_start,
  input  logic          keep_train,
  input  logic          req_q,
  input  logic          eop_q,
  output sect_e         sect_q,
  output sect_e         sect_n,
  output logic [IW-1:0] idx_n
);
  logic [IW-1:0] idx_q;

  always_comb begin
    sect_n = sect_q;
    idx_n  = idx_q + 1'b1;
    unique case (sect_q)
      SEC_IDLE: begin
        idx_n = '0;
        if (phase_start) sect_n = keep_train ? SEC_DATA : SEC_A_HOLD;
      end
      SEC_A_HOLD: if (idx_q == IW'(A_HOLD_SLOTS - 1)) begin
        sect_n = SEC_A_TOG;
        idx_n  = '0;
      end
      SEC_A_TOG: if (idx_q == IW'(A_TOG_SLOTS - 1)) begin
        sect_n = SEC_B;
        idx_n  = '0;
      end
      SEC_B: if (idx_q == IW'(B_SLOTS - 1)) begin
        sect_n = SEC_C;
        idx_n  = '0;
      end
      SEC_C: if (idx_q == IW'(C_SLOTS - 1)) begin
        sect_n = SEC_DATA;
        idx_n  = '0;
      end
      SEC_DATA: begin
        idx_n = '0;
        if (!req_q && eop_q) sect_n = SEC_IDLE;
      end
      default: begin
        sect_n = SEC_IDLE;
        idx_n  = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sect_q <= SEC_IDLE;
      idx_q  <= '0;
    end else begin
      sect_q <= sect_n;
      idx_q  <= idx_n;
    end
  end

  AST_HOLD_TO_TOG: assert property (@(posedge clk) disable iff (rst)
    (sect_q == SEC_A_HOLD) |=> (sect_q inside {SEC_A_HOLD, SEC_A_TOG})); // R2
  AST_B_TO_C: assert property (@(posedge clk) disable iff (rst)
    (sect_q == SEC_B) |=> (sect_q inside {SEC_B, SEC_C})); // R4
  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (sect_q inside {SEC_A_TOG, SEC_B, SEC_C, SEC_DATA}) |=> (sect_q != SEC_A_HOLD)); // R13
endmodule

// File: rtl/dtx_train_pattern.sv
module dtx_train_pattern
  import dtx_pkg::*;
#(
  parameter int DW = 16
) (
  input  sect_e         sect,
  input  logic [3:0]    idx,
  output logic [DW-1:0] db_t,
  output logic          crca_t,
  output logic          p1_t,
  output logic          req_t
);
  logic ser_bit;

  always_comb begin
    ser_bit = C_SERIAL[4'd15 - idx];
    db_t    = '0;
    crca_t  = 1'b0;
    p1_t    = 1'b0;
    req_t   = 1'b0;
    unique case (sect)
      SEC_A_TOG: begin
        req_t  = ~idx[0];
        db_t   = {DW{~idx[0]}};
        crca_t = ~idx[0];
        p1_t   = ~idx[0];
      end
      SEC_B: begin
        req_t  = ~idx[0];
        db_t   = {DW{~idx[1]}};
        crca_t = ~idx[1];
        p1_t   = ~idx[1];
      end
      SEC_C: begin
        req_t  = ~idx[0];
        db_t   = {DW{ser_bit}};
        crca_t = ser_bit;
        p1_t   = ~idx[1];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dtx_drive_boost.sv
module dtx_drive_boost #(
  parameter int NL = 19
) (
  input  logic          en,
  input  logic [NL-1:0] cur,
  input  logic [NL-1:0] nxt,
  output logic [NL-1:0] boost
);
  for (genvar i = 0; i < NL; i++) begin : g_line
    assign boost[i] = en & (cur[i] ^ nxt[i]);
  end
endmodule

// File: rtl/dtx_link_tx.sv
module dtx_link_tx
  import dtx_pkg::*;
#(
  parameter int DW           = 16,
  parameter int A_HOLD_SLOTS = 32,
  parameter int A_TOG_SLOTS  = 128,
  parameter int B_SLOTS      = 48,
  parameter int C_REPS       = 8,
  parameter logic [DW-1:0] FILL_WORD = {(DW/8){8'h5A}}
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            phase_start,
  input  logic            keep_train,
  input  logic            pcomp_en,
  input  logic            src_valid,
  output logic            src_ready,
  input  logic [2*DW-1:0] src_data,
  input  logic            src_last_unit,
  input  logic            src_end,
  output logic [DW-1:0]   db_out,
  output logic            crca_out,
  output logic            p1_out,
  output logic            req_out,
  output logic [DW+2:0]   drv_boost,
  output logic            done
);
  localparam int C_SLOTS = 16 * C_REPS;
  localparam int MAX_AB  = (A_HOLD_SLOTS > A_TOG_SLOTS) ? A_HOLD_SLOTS : A_TOG_SLOTS;
  localparam int MAX_BC  = (B_SLOTS > C_SLOTS) ? B_SLOTS : C_SLOTS;
  localparam int MAXS    = (MAX_AB > MAX_BC) ? MAX_AB : MAX_BC;
  localparam int IW      = $clog2(MAXS);
  localparam int NL      = DW + 3;

  sect_e         sect_q, sect_n;
  logic [IW-1:0] idx_n;

  logic [DW-1:0] db_q, db_n, hi_q, hi_n, db_t;
  logic          crca_q, crca_n, p1_q, p1_n, req_q, req_n;
  logic          crca_t, p1_t, req_t;
  logic          vld_q, vld_n, lastu_q, lastu_n, eop_q, eop_n;
  logic          done_q, done_n, take;
  logic [NL-1:0] lines_q, lines_n, boost_q, boost_n;

  dtx_seq_ctl #(
    .A_HOLD_SLOTS(A_HOLD_SLOTS), .A_TOG_SLOTS(A_TOG_SLOTS),
    .B_SLOTS(B_SLOTS), .C_SLOTS(C_SLOTS), .IW(IW)
  ) u_seq (
    .clk(clk), .rst(rst), .phase_start(phase_start), .keep_train(keep_train),
    .req_q(req_q), .eop_q(eop_q), .sect_q(sect_q), .sect_n(sect_n), .idx_n(idx_n)
  );

  dtx_train_pattern #(.DW(DW)) u_pat (
    .sect(sect_n), .idx(idx_n[3:0]),
    .db_t(db_t), .crca_t(crca_t), .p1_t(p1_t), .req_t(req_t)
  );

  // A pair is taken only when the next slot is a rising data slot.
  assign src_ready = (sect_n == SEC_DATA) && !req_q;
  assign take      = src_valid && src_ready;

  always_comb begin
    db_n    = db_t;
    crca_n  = crca_t;
    p1_n    = p1_t;
    req_n   = req_t;
    hi_n    = hi_q;
    vld_n   = 1'b0;
    lastu_n = 1'b0;
    eop_n   = 1'b0;
    if (sect_n == SEC_DATA) begin
      if (!req_q) begin
        req_n   = 1'b1;
        vld_n   = take;
        lastu_n = take && src_last_unit;
        eop_n   = take && src_end;
        hi_n    = src_data[2*DW-1:DW];
        db_n    = take ? src_data[DW-1:0] : FILL_WORD;
        crca_n  = take && src_last_unit;
        p1_n    = (take != vld_q) ? p1_q : ~p1_q;
      end else begin
        req_n   = 1'b0;
        vld_n   = vld_q;
        lastu_n = lastu_q;
        eop_n   = eop_q;
        db_n    = vld_q ? hi_q : FILL_WORD;
        crca_n  = vld_q && lastu_q;
        p1_n    = p1_q;
      end
    end
  end

  assign lines_q = {req_q, p1_q, crca_q, db_q};
  assign lines_n = {req_n, p1_n, crca_n, db_n};
  assign done_n  = (sect_q == SEC_DATA) && (sect_n == SEC_IDLE);

  dtx_drive_boost #(.NL(NL)) u_boost (
    .en(pcomp_en), .cur(lines_q), .nxt(lines_n), .boost(boost_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      db_q    <= '0;
      hi_q    <= '0;
      crca_q  <= 1'b0;
      p1_q    <= 1'b0;
      req_q   <= 1'b0;
      vld_q   <= 1'b0;
      lastu_q <= 1'b0;
      eop_q   <= 1'b0;
      done_q  <= 1'b0;
      boost_q <= '0;
    end else begin
      db_q    <= db_n;
      hi_q    <= hi_n;
      crca_q  <= crca_n;
      p1_q    <= p1_n;
      req_q   <= req_n;
      vld_q   <= vld_n;
      lastu_q <= lastu_n;
      eop_q   <= eop_n;
      done_q  <= done_n;
      boost_q <= boost_n;
    end
  end

  assign db_out    = db_q;
  assign crca_out  = crca_q;
  assign p1_out    = p1_q;
  assign req_out   = req_q;
  assign drv_boost = boost_q;
  assign done      = done_q;

  AST_REQ_ALT: assert property (@(posedge clk) disable iff (rst)
    req_q |=> !req_q); // R7
  AST_READY_THEN_RISE: assert property (@(posedge clk) disable iff (rst)
    src_ready |=> req_q); // R7
  AST_P1_STILL_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (req_q && (sect_q inside {SEC_C, SEC_DATA})) |=> $stable(p1_q)); // R8
  AST_FILL_NO_CRCA: assert property (@(posedge clk) disable iff (rst)
    (sect_q == SEC_DATA && !vld_q) |-> !crca_q); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R11
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (lines_q == '0)); // R11
  AST_BOOST_DIFF: assert property (@(posedge clk) disable iff (rst)
    $past(pcomp_en) |-> (boost_q == (lines_q ^ $past(lines_q)))); // R12
  AST_BOOST_OFF: assert property (@(posedge clk) disable iff (rst)
    !$past(pcomp_en) |-> (boost_q == '0)); // R12
endmodule

// File: tb/tb_dtx_link_tx.sv
`timescale 1ns/1ps
module tb_dtx_link_tx;
  localparam int DW = 16;
  localparam int NL = DW + 3;
  localparam int TRAIN = 32 + 128 + 48 + 128;
  localparam logic [DW-1:0] FILL = 16'h5A5A;
  localparam logic [15:0] SER = 16'b0000010011111011;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic phase_start = 1'b0, keep_train = 1'b0, pcomp_en = 1'b0;
  logic src_valid = 1'b0, src_ready, src_last_unit = 1'b0, src_end = 1'b0;
  logic [2*DW-1:0] src_data = '0;
  logic [DW-1:0] db_out;
  logic crca_out, p1_out, req_out, done;
  logic [NL-1:0] drv_boost;

  dtx_link_tx dut (
    .clk(clk), .rst(rst), .phase_start(phase_start), .keep_train(keep_train),
    .pcomp_en(pcomp_en), .src_valid(src_valid), .src_ready(src_ready),
    .src_data(src_data), .src_last_unit(src_last_unit), .src_end(src_end),
    .db_out(db_out), .crca_out(crca_out), .p1_out(p1_out), .req_out(req_out),
    .drv_boost(drv_boost), .done(done)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int            due;
    logic [NL-1:0] lines;
    logic [NL-1:0] boost;
    logic          dn;
    string         tag;
  } exp_t;

  exp_t q[$];
  exp_t mon_e;
  int n_chk = 0, n_fail = 0;
  logic [NL-1:0] prev_lines = '0;
  bit cur_pcomp = 0;

  task automatic push(input logic [NL-1:0] ln, input logic dn, input string tg);
    exp_t e;
    e.due   = cyc + 1;
    e.lines = ln;
    e.boost = cur_pcomp ? (ln ^ prev_lines) : '0;
    e.dn    = dn;
    e.tag   = tg;
    prev_lines = ln;
    q.push_back(e);
  endtask

  function automatic logic [DW-1:0] lo_w(input int j);
    return 16'(j * 16'h1357 + 16'h0101);
  endfunction
  function automatic logic [DW-1:0] hi_w(input int j);
    return 16'(j * 16'h0F31 + 16'hC003);
  endfunction

  task automatic train_exp(input int s, output logic [NL-1:0] ln, output string tg);
    logic b, r, v;
    int k;
    if (s < 32) begin
      ln = '0; tg = "R2";
    end else if (s < 160) begin
      k = s - 32; b = (k % 2 == 0);
      ln = {b, b, b, {DW{b}}}; tg = "R3";
    end else if (s < 208) begin
      k = s - 160; r = (k % 2 == 0); v = (k % 4 < 2);
      ln = {r, v, v, {DW{v}}}; tg = "R4";
    end else begin
      k = s - 208; r = (k % 2 == 0); v = (k % 4 < 2); b = SER[15 - (k % 16)];
      ln = {r, v, b, {DW{b}}}; tg = "R5";
    end
  endtask

  task automatic check(input bit ok, input string tg, input string what,
                       input logic [31:0] got, input logic [31:0] want);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s got %h expected %h", tg, what, got, want);
    end
  endtask

  // Monitor: compare each expected slot in the cycle it is due.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due < cyc) begin
      mon_e = q.pop_front();
      check(0, mon_e.tag, "slot missed", 32'(cyc), 32'(mon_e.due));
    end
    if (q.size() > 0 && q[0].due == cyc) begin
      mon_e = q.pop_front();
      check({req_out, p1_out, crca_out, db_out} === mon_e.lines, mon_e.tag,
            "lines", 32'({req_out, p1_out, crca_out, db_out}), 32'(mon_e.lines));
      check(drv_boost === mon_e.boost, {"R12 ", mon_e.tag}, "boost",
            32'(drv_boost), 32'(mon_e.boost));
      check(done === mon_e.dn, {"R11 ", mon_e.tag}, "done", 32'(done), 32'(mon_e.dn));
    end
  end

  // Driver: one phase, stepping a slot per cycle.
  task automatic run_phase(input bit keep, input bit pc, input int npairs,
                           input logic [31:0] gap_mask, input int lastu_from,
                           input int restart_at);
    int t, total, j;
    bit rising, vld, lu, exp_vld;
    logic exp_p1;
    logic [NL-1:0] ln;
    string tg;
    @(posedge clk); #2;
    cur_pcomp = pc; pcomp_en = pc; keep_train = keep;
    t = keep ? 0 : TRAIN;
    total = t + 2 * npairs;
    exp_vld = 0; exp_p1 = 1'b0;
    for (int s = 0; s < total; s++) begin
      phase_start = (s == 0) || (s == restart_at);
      src_valid = 1'b1; src_data = 32'hDEAD_BEEF; src_last_unit = 1'b1; src_end = 1'b1;
      if (s < t) begin
        train_exp(s, ln, tg);
        rising = 0;
      end else begin
        j = (s - t) / 2;
        rising = ((s - t) % 2 == 0);
        vld = !gap_mask[j];
        lu = (j >= lastu_from);
        if (rising) begin
          src_valid = vld;
          src_data = {hi_w(j), lo_w(j)};
          src_last_unit = lu;
          src_end = (j == npairs - 1);
          if (vld == exp_vld) exp_p1 = ~exp_p1;
          exp_vld = vld;
          ln = {1'b1, exp_p1, vld & lu, vld ? lo_w(j) : FILL};
        end else begin
          ln = {1'b0, exp_p1, vld & lu, vld ? hi_w(j) : FILL};
        end
        tg = !vld ? "R9 R8" : (lu ? "R10 R7 R8" : "R7 R8");
      end
      if (keep && s == 0) tg = {tg, " R6"};
      if (s == restart_at) tg = {tg, " R13"};
      push(ln, 1'b0, tg);
      #1;
      check(src_ready === rising, "R7", "src_ready", 32'(src_ready), 32'(rising));
      @(posedge clk); #2;
    end
    phase_start = 1'b0; src_valid = 1'b0; src_last_unit = 1'b0; src_end = 1'b0;
    push('0, 1'b1, "R11 end");
    @(posedge clk); #2;
    push('0, 1'b0, "R11 after");
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    check({req_out, p1_out, crca_out, db_out} === '0, "R1", "lines",
          32'({req_out, p1_out, crca_out, db_out}), 32'h0);
    check(drv_boost === '0, "R1", "boost", 32'(drv_boost), 32'h0);
    check(done === 1'b0, "R1", "done", 32'(done), 32'h0);
    check(src_ready === 1'b0, "R1", "src_ready", 32'(src_ready), 32'h0);
    // Full training, precompensation on, gaps, last-unit tail, restart mid-training.
    run_phase(0, 1, 6, 32'b001010, 4, 100);
    // Retained training, precompensation off, leading gaps, restart inside data.
    run_phase(1, 0, 8, 32'b0010_0011, 6, TRAIN + 5 - TRAIN);
    // Retained training, all valid, no last unit.
    run_phase(1, 1, 4, 32'b0, 99, -1);
    // Full training with a single pair, precompensation off.
    run_phase(0, 0, 1, 32'b0, 0, 300);
    while (q.size() > 0) @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule